// File: doc/BRIEF.md
# Lung-Feedback Double-Precision Random Word Generator

This block produces a stream of 128-bit pseudorandom words. Each word is read as two 64-bit double-precision values, and each of those values lies in the range [1, 2). The generator keeps a circular store of 191 state words and one extra 128-bit feedback register, called the lung. Each accepted request runs one step of the recurrence in a single clock cycle. A step reads the word at the current position and a second word 117 positions further on, and it reads the lung. It then writes a new word back over the current position and updates the lung.

Every stored word has sign 0 and exponent 0x3ff in both 64-bit lanes, and the recurrence never changes those 12 bits. As a result, each output is a valid double with no conversion step. Subtracting 1.0 in software maps a value onto [0, 1).

Before any request is accepted, software fills the store through a seed port, one word per cycle, and then supplies the lung. A request is only accepted while the ready output is high. Each accepted request returns the newly written word one cycle later, together with a one-cycle valid strobe.

Top module: `plfsr_dgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rdy_o` and `out_valid_o` are both 0.
- R2: When the generator is not loaded, seed beats 0 to 190 write positions 0 to 190 in order. Bits [63:52] and [127:116] of each stored word are forced to 0x3ff, and all other bits are taken from `seed_data_i`. Beat 191 loads the lung unchanged. `rdy_o` goes to 1 in the cycle after that beat.
- R3: During loading `rdy_o` stays 0 and `req_i` is ignored: no `out_valid_o` is produced.
- R4: A request is accepted when `req_i` and `rdy_o` are both 1 at a clock edge. After that edge `out_valid_o` is 1 for exactly one cycle and `out_word_o` holds the newly written word. Without an accepted request, `out_valid_o` is 0.
- R5: One step works as follows. Let wa be the word at the current position, wb the word 117 positions further on (modulo 191), and u the lung. For each 64-bit lane, the new lung is (wa shifted left by 19) XOR wb XOR (u with its two 32-bit halves swapped). For each lane, the new word is wa XOR ((new lung shifted right by 12) AND mask). The mask is 0x000ffafffffffb3f000ffdfffc90fffd.
- R6: Every valid output word has 0x3ff in bits [127:116] and in bits [63:52].
- R7: The k-th step after a load uses the current position k mod 191, and that position wraps from 190 back to 0. The recurrence stays correct across more than 191 consecutive steps.
- R8: A seed beat while the generator is loaded restarts loading at position 0 and clears `rdy_o`. If a request arrives in the same cycle as that beat, the seed beat wins: the request is dropped and no `out_valid_o` follows.
- R9: Requests held high on consecutive cycles give one output word per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid_i | input | 1 | Seed beat strobe |
| seed_data_i | input | 128 | Seed word (store beats) or lung value (final beat) |
| req_i | input | 1 | Step request |
| rdy_o | output | 1 | Generator loaded and able to accept a request |
| out_valid_o | output | 1 | One-cycle strobe for `out_word_o` |
| out_word_o | output | 128 | Two doubles in [1, 2), one per 64-bit lane |

## Verification
A seed beat and a step request can fall in the same cycle. The bench provokes this once the generator is loaded: it raises `seed_valid_i` and `req_i` on the same edge. It then expects no valid strobe and `rdy_o` low, and it requires that the outputs after the completed reload follow a reference model restarted from the new seed. The bench also holds `req_i` high for the whole of a load, which shows that requests are dropped while loading. It then runs 400 back-to-back steps, checked word by word against the model, so that both the current position and the pick-up position wrap.

// File: rtl/plfsr_pkg.sv
package plfsr_pkg;
   localparam int unsigned WORD_W_D  = 128;
   localparam int unsigned LANE_W_D  = 64;
   localparam int unsigned FRAC_W_D  = 52;
   localparam int unsigned DEPTH_D   = 191;
   localparam int unsigned PICK_D    = 117;
   localparam int unsigned SHL_D     = 19;
   localparam int unsigned SHR_D     = 12;
   localparam logic [WORD_W_D-1:0] MASK_D = 128'h000ffafffffffb3f000ffdfffc90fffd;
   localparam logic [11:0] SIGN_EXP_D = 12'h3ff;
endpackage

// File: rtl/plfsr_state_ram.sv
module plfsr_state_ram #(
   parameter int unsigned W     = 128,
   parameter int unsigned DEPTH = 191,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/plfsr_recur.sv
module plfsr_recur #(
   parameter int unsigned W      = 128,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned SHL    = 19,
   parameter int unsigned SHR    = 12,
   parameter logic [W-1:0] MASK  = '0,
   localparam int unsigned LANES = W / LANE_W,
   localparam int unsigned HALF  = LANE_W / 2
) (
   input  logic [W-1:0] wa,
   input  logic [W-1:0] wb,
   input  logic [W-1:0] u_prev,
   output logic [W-1:0] u_next,
   output logic [W-1:0] w_next
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned LO = l * LANE_W;
      logic [LANE_W-1:0] a_term;
      logic [LANE_W-1:0] b_term;
      logic [LANE_W-1:0] u_l;
      assign a_term = wa[LO +: LANE_W] << SHL;
      assign b_term = {u_prev[LO +: HALF], u_prev[LO+HALF +: HALF]};
      assign u_l    = a_term ^ wb[LO +: LANE_W] ^ b_term;
      assign u_next[LO +: LANE_W] = u_l;
      assign w_next[LO +: LANE_W] = wa[LO +: LANE_W] ^ ((u_l >> SHR) & MASK[LO +: LANE_W]);
   end
endmodule

// File: rtl/plfsr_dgen.sv
module plfsr_dgen
   import plfsr_pkg::*;
#(
   parameter int unsigned W      = WORD_W_D,
   parameter int unsigned LANE_W = LANE_W_D,
   parameter int unsigned FRAC_W = FRAC_W_D,
   parameter int unsigned DEPTH  = DEPTH_D,
   parameter int unsigned PICK   = PICK_D,
   parameter int unsigned SHL    = SHL_D,
   parameter int unsigned SHR    = SHR_D,
   parameter logic [W-1:0] MASK  = MASK_D,
   parameter logic [LANE_W-FRAC_W-1:0] SIGN_EXP = SIGN_EXP_D
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_valid_i,
   input  logic [W-1:0] seed_data_i,
   input  logic         req_i,
   output logic         rdy_o,
   output logic         out_valid_o,
   output logic [W-1:0] out_word_o
);
   localparam int unsigned LANES = W / LANE_W;
   localparam int unsigned SE_W  = LANE_W - FRAC_W;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   function automatic logic [W-1:0] f_rep(input logic [LANE_W-1:0] lane);
      logic [W-1:0] r;
      for (int i = 0; i < int'(LANES); i++) r[i*LANE_W +: LANE_W] = lane;
      return r;
   endfunction

   localparam logic [W-1:0] EXP_WORD  = f_rep({SIGN_EXP, {FRAC_W{1'b0}}});
   localparam logic [W-1:0] FRAC_KEEP = f_rep({{SE_W{1'b0}}, {FRAC_W{1'b1}}});

   // elaboration-time parameter checks
   if (W % LANE_W != 0) begin : g_bad_lane
      $error("word width must be a multiple of the lane width");
   end
   if (FRAC_W >= LANE_W || LANE_W % 2 != 0) begin : g_bad_frac
      $error("fraction width must be below an even lane width");
   end
   if (PICK == 0 || PICK >= DEPTH - 1) begin : g_bad_pick
      $error("pick-up offset out of range");
   end
   if (SHR < SE_W) begin : g_bad_shr
      $error("right shift must clear the sign and exponent field");
   end
   for (genvar l = 0; l < LANES; l++) begin : g_mask_chk
      if (MASK[l*LANE_W+LANE_W-1 -: SE_W] != '0) begin : g_bad_mask
         $error("mask touches a sign or exponent bit");
      end
   end

   logic          loaded;
   logic [CW-1:0] seed_cnt;
   logic [AW-1:0] pos;
   logic [AW-1:0] pick_pos;
   logic [AW:0]   pick_sum;
   logic [W-1:0]  lung;
   logic [W-1:0]  wa, wb, u_next, w_next;
   logic          store_beat, lung_beat, step;
   logic          ram_we;
   logic [AW-1:0] ram_waddr;
   logic [W-1:0]  ram_wdata;
   logic [W-1:0]  seed_forced;

   assign store_beat  = seed_valid_i & (loaded | (seed_cnt < CW'(DEPTH)));
   assign lung_beat   = seed_valid_i & ~loaded & (seed_cnt == CW'(DEPTH));
   assign step        = req_i & loaded & ~seed_valid_i;
   assign seed_forced = (seed_data_i & FRAC_KEEP) | EXP_WORD;

   assign pick_sum = {1'b0, pos} + (AW+1)'(PICK);
   assign pick_pos = (pick_sum >= (AW+1)'(DEPTH)) ? AW'(pick_sum - (AW+1)'(DEPTH))
                                                  : AW'(pick_sum);

   assign ram_we    = store_beat | step;
   assign ram_waddr = store_beat ? (loaded ? '0 : AW'(seed_cnt)) : pos;
   assign ram_wdata = store_beat ? seed_forced : w_next;

   plfsr_state_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .we      (ram_we),
      .waddr   (ram_waddr),
      .wdata   (ram_wdata),
      .raddr_a (pos),
      .raddr_b (pick_pos),
      .rdata_a (wa),
      .rdata_b (wb)
   );

   plfsr_recur #(.W(W), .LANE_W(LANE_W), .SHL(SHL), .SHR(SHR), .MASK(MASK)) u_recur (
      .wa     (wa),
      .wb     (wb),
      .u_prev (lung),
      .u_next (u_next),
      .w_next (w_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded      <= 1'b0;
         seed_cnt    <= '0;
         pos         <= '0;
         lung        <= '0;
         out_valid_o <= 1'b0;
         out_word_o  <= '0;
      end else begin
         out_valid_o <= step;
         if (seed_valid_i) begin
            if (loaded) begin
               loaded   <= 1'b0;
               seed_cnt <= CW'(1);
            end else if (lung_beat) begin
               lung     <= seed_data_i;
               loaded   <= 1'b1;
               seed_cnt <= '0;
               pos      <= '0;
            end else begin
               seed_cnt <= seed_cnt + CW'(1);
            end
         end else if (step) begin
            lung       <= u_next;
            out_word_o <= w_next;
            pos        <= (pos == AW'(DEPTH - 1)) ? '0 : pos + AW'(1);
         end
      end
   end

   assign rdy_o = loaded;
endmodule

// File: rtl/plfsr_dgen_chk.sv
module plfsr_dgen_chk #(
   parameter int unsigned W      = 128,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned SE_W   = 12,
   parameter logic [SE_W-1:0] SIGN_EXP = 12'h3ff
) (
   input logic         clk,
   input logic         rst_n,
   input logic         seed_valid_i,
   input logic         req_i,
   input logic         rdy_o,
   input logic         out_valid_o,
   input logic [W-1:0] out_word_o
);
   p_valid_from_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(req_i & rdy_o & ~seed_valid_i));

   p_exp_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_word_o[W-1 -: SE_W] == SIGN_EXP) &&
                      (out_word_o[LANE_W-1 -: SE_W] == SIGN_EXP));

   p_rdy_after_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> $past(seed_valid_i));

   p_seed_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seed_valid_i |=> !out_valid_o);

   p_reload_drops_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_valid_i && rdy_o) |=> !rdy_o);
endmodule

bind plfsr_dgen plfsr_dgen_chk #(.W(W), .LANE_W(LANE_W), .SE_W(LANE_W - FRAC_W),
                                 .SIGN_EXP(SIGN_EXP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .seed_valid_i (seed_valid_i),
   .req_i        (req_i),
   .rdy_o        (rdy_o),
   .out_valid_o  (out_valid_o),
   .out_word_o   (out_word_o)
);

// File: tb/plfsr_dgen_bench.sv
module plfsr_dgen_bench;
   localparam int DEPTH = 191;
   localparam int PICK  = 117;
   localparam logic [127:0] MASK = 128'h000ffafffffffb3f000ffdfffc90fffd;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         seed_valid_i = 1'b0;
   logic [127:0] seed_data_i = '0;
   logic         req_i = 1'b0;
   logic         rdy_o, out_valid_o;
   logic [127:0] out_word_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [127:0] m_arr [DEPTH];
   logic [127:0] m_lung;
   int           m_pos;

   always #5 clk = ~clk;

   plfsr_dgen u_plfsr_dgen (
      .clk(clk), .rst_n(rst_n), .seed_valid_i(seed_valid_i), .seed_data_i(seed_data_i),
      .req_i(req_i), .rdy_o(rdy_o), .out_valid_o(out_valid_o), .out_word_o(out_word_o)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mix(input logic [63:0] x);
      logic [63:0] y = x * 64'h9e3779b97f4a7c15;
      return y ^ (y >> 29) ^ (y << 17);
   endfunction

   function automatic logic [127:0] force_exp(input logic [127:0] d);
      return {12'h3ff, d[115:64], 12'h3ff, d[51:0]};
   endfunction

   // reference step per R5 and R7
   function automatic logic [127:0] model_step();
      logic [127:0] wa = m_arr[m_pos];
      logic [127:0] wb = m_arr[(m_pos + PICK) % DEPTH];
      logic [127:0] u, w;
      for (int l = 0; l < 2; l++) begin
         logic [63:0] a = wa[l*64 +: 64] << 19;
         logic [63:0] b = {m_lung[l*64 +: 32], m_lung[l*64+32 +: 32]};
         u[l*64 +: 64] = a ^ wb[l*64 +: 64] ^ b;
         w[l*64 +: 64] = wa[l*64 +: 64] ^ ((u[l*64 +: 64] >> 12) & MASK[l*64 +: 64]);
      end
      m_arr[m_pos] = w;
      m_lung = u;
      m_pos = (m_pos + 1) % DEPTH;
      return w;
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 rdy in reset", 128'(rdy_o), 128'(0));
      chk("R1 valid in reset", 128'(out_valid_o), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdy after reset", 128'(rdy_o), 128'(0));
      chk("R1 valid after reset", 128'(out_valid_o), 128'(0));
   endtask

   // loads beats first..190 then lung; req held high to show it is ignored (R3)
   task automatic t_load(input logic [63:0] base, input int first);
      for (int k = first; k < DEPTH; k++) begin
         seed_valid_i = 1'b1;
         req_i = 1'b1;
         seed_data_i = {mix(base + 64'(2*k)), mix(base + 64'(2*k + 1))};
         m_arr[k] = force_exp(seed_data_i);
         @(negedge clk);
         chk("R3 rdy low while loading", 128'(rdy_o), 128'(0));
         chk("R3 no valid while loading", 128'(out_valid_o), 128'(0));
      end
      seed_data_i = {mix(base ^ 64'h55), mix(base ^ 64'haa)};
      m_lung = seed_data_i;
      m_pos = 0;
      @(negedge clk);
      chk("R2 rdy after lung beat", 128'(rdy_o), 128'(1));
      chk("R3 no valid on lung beat", 128'(out_valid_o), 128'(0));
      seed_valid_i = 1'b0;
      req_i = 1'b0;
      seed_data_i = '0;
   endtask

   task automatic t_run(input int n, input bit gap);
      for (int i = 0; i < n; i++) begin
         logic [127:0] exp_w;
         req_i = 1'b1;
         exp_w = model_step();
         @(negedge clk);
         chk("R4 valid after request", 128'(out_valid_o), 128'(1));
         chk(i >= DEPTH ? "R7 word after wrap" : "R5 output word", out_word_o, exp_w);
         chk("R6 exponent fields", {out_word_o[127:116], out_word_o[63:52]}, {12'h3ff, 12'h3ff});
         if (gap) begin
            req_i = 1'b0;
            @(negedge clk);
            chk("R4 single-cycle strobe", 128'(out_valid_o), 128'(0));
         end
      end
      if (!gap) begin
         req_i = 1'b0;
         @(negedge clk);
         chk("R9 valid ends with requests", 128'(out_valid_o), 128'(0));
      end
   endtask

   task automatic t_collide(input logic [63:0] base);
      seed_valid_i = 1'b1;
      req_i = 1'b1;
      seed_data_i = {mix(base), mix(base + 64'd1)};
      m_arr[0] = force_exp(seed_data_i);
      @(negedge clk);
      chk("R8 request dropped on seed beat", 128'(out_valid_o), 128'(0));
      chk("R8 rdy cleared by reload", 128'(rdy_o), 128'(0));
      t_load(base, 1);
      t_run(200, 1'b0);
   endtask

   initial begin
      t_reset();
      t_load(64'h1234, 0);
      t_run(5, 1'b1);
      t_run(400, 1'b0);
      t_collide(64'hbeef);
      @(negedge clk);
      chk("R4 idle no valid", 128'(out_valid_o), 128'(0));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule